// File: doc/BRIEF.md
# ROM Entry List Walker

This block walks the chain of variable-length records stored after the fixed 22-byte header of a descriptor image. The image sits in a byte-wide memory with a synchronous read port. On `start`, the walker reads each record's length byte and its flags byte. A record is either a generic entry or a port entry. For enabled port entries it also reads the two body bytes that carry link and partner information. It then emits one decoded record on a valid/ready stream and steps forward by the record's length until it reaches the image size given on `total_size`.

Malformed chains end the walk with an error:

- a zero length,
- a record that would run past the image,
- a record that starts on the image's final byte,
- an enabled port record whose length is not exactly 8.

A clean end of the chain raises `done`. Generic records with index 1 or 2 are tagged as vendor-name or device-name strings, and their payload length is reported. The string bytes themselves are not fetched.

The controller is a single state machine with these states:

- IDLE: waits after reset.
- WALK: tests the position against the size and fetches the length byte.
- LEN: checks the length and fetches the flags byte.
- FLAGS: classifies the record and fetches body byte 2 when needed.
- BODY2: captures link and dual flag, then fetches body byte 3.
- BODY3: captures the partner number.
- EMIT: presents the record.
- DONE: clean end of the chain.
- FAIL: the walk stopped on an error.

Its transitions are:

- start (IDLE, DONE or FAIL to WALK)
- end-of-list (WALK to DONE)
- last-byte overrun (WALK to FAIL)
- length accepted (LEN to FLAGS)
- length rejected (LEN to FAIL)
- no body needed (FLAGS to EMIT)
- body needed (FLAGS to BODY2)
- bad port length (FLAGS to FAIL)
- body step (BODY2 to BODY3)
- body done (BODY3 to EMIT)
- accepted (EMIT to WALK)

Top module: `rom_list_walker`

## Requirements
- R1: After reset, `rec_valid`, `done`, `error`, `busy` and `mem_rd_en` are all low.
- R2: A walk begins at byte offset 22 and ends with `done` high and `err_kind` = 0 once the position is at or beyond `total_size`; a size of 22 yields `done` with no records.
- R3: Record byte 0 is its total length, including the two header bytes. In record byte 1, bits 5:0 give `rec_index` and bit 7 gives the type (0 generic, 1 port, reported on `rec_is_port`). Bit 6 is the disabled flag; it is reported on `rec_disabled` for port records only and reads 0 for generic records.
- R4: The walk stops with `error` high and `err_kind` = 1 (overrun), and emits no record for the offending entry, in three cases: the length is zero, position plus length exceeds `total_size`, or the position equals `total_size` minus 1.
- R5: An enabled port record (type 1, disabled 0) whose length is not 8 stops the walk with `error` high and `err_kind` = 2.
- R6: For an enabled port record, `rec_link` is bit 4 of record byte 2 and `rec_has_dual` is bit 7 of byte 2. `rec_dual_port` is bits 5:0 of byte 3 when the dual flag is set and 0 otherwise.
- R7: A disabled port record is reported with its index and `rec_disabled` = 1; its body is not read, `rec_link`, `rec_has_dual` and `rec_dual_port` are 0, and any in-bounds length is accepted.
- R8: A generic record with index 1 gets `rec_str_tag` = 1 (vendor name), index 2 gets 2 (device name), other records get 0. `rec_payload_len` is the length minus 2 for tagged records with length of at least 2, and 0 otherwise.
- R9: After each accepted record the position advances by that record's length, so records appear in chain order, one per entry.
- R10: While `rec_valid` is high and `rec_ready` is low, `rec_valid` stays high and every record field holds its value.
- R11: Each memory read is an address with `mem_rd_en` high; its data is taken from `mem_rdata` one cycle later. Every read address is at least 22 and below `total_size`.
- R12: `done` and `error` are never high together; each stays high until the next `start`; `err_kind` is nonzero exactly when `error` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when not busy) |
| total_size | input | AW | Image size in bytes, held for the whole walk |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory byte address |
| mem_rdata | input | 8 | Memory data, one cycle after the strobe |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_is_port | output | 1 | 1 for port records, 0 for generic |
| rec_index | output | 6 | Record index |
| rec_disabled | output | 1 | Port is disabled |
| rec_link | output | 1 | Link number of an enabled port |
| rec_has_dual | output | 1 | Port has a dual-link partner |
| rec_dual_port | output | 6 | Partner port number |
| rec_str_tag | output | 2 | 0 none, 1 vendor name, 2 device name |
| rec_payload_len | output | 8 | String payload length |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Chain ended cleanly |
| error | output | 1 | Walk stopped on a malformed chain |
| err_kind | output | 2 | 0 none, 1 overrun, 2 bad port length |

## Verification
A wrong position register shows up at the ports on the very next read. The address leaves the window between byte 22 and `total_size`, or the following record decodes from shifted bytes. Either way the record stream diverges within one record, about four to six cycles. A state machine that loses its place shows as a record that drops during back-pressure, a body field leaking into a disabled or generic record, or `done` and `error` raised in the wrong case. The sweeps cover every flags byte, every length from 0 to 12 against exact and loose sizes, and chained lists under three ready patterns. Each run is compared record by record with a model computed from the requirements.

// File: rtl/rlw_pkg.sv
`timescale 1ns/1ps
package rlw_pkg;

    localparam int IDX_W      = 6;
    localparam int TYPE_BIT   = 7;
    localparam int DIS_BIT    = 6;
    localparam int LINK_BIT   = 4;
    localparam int DUAL_BIT   = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WALK,
        ST_LEN,
        ST_FLAGS,
        ST_BODY2,
        ST_BODY3,
        ST_EMIT,
        ST_DONE,
        ST_FAIL
    } walk_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_OVERRUN = 2'd1,
        ERR_PORTLEN = 2'd2
    } walk_err_e;

    typedef enum logic [1:0] {
        TAG_NONE   = 2'd0,
        TAG_VENDOR = 2'd1,
        TAG_DEVICE = 2'd2
    } str_tag_e;

    typedef struct packed {
        logic             is_port;
        logic [IDX_W-1:0] index;
        logic             disabled;
        logic             link;
        logic             has_dual;
        logic [IDX_W-1:0] dual_port;
        str_tag_e         tag;
        logic [7:0]       payload_len;
    } walk_rec_t;

endpackage

// File: rtl/rlw_bounds.sv
`timescale 1ns/1ps
module rlw_bounds #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] pos,
    input  logic [AW-1:0] size,
    input  logic [7:0]    len,
    output logic          at_end,
    output logic          last_byte,
    output logic          len_bad
);
    localparam int SW = AW + 1;

    logic [SW-1:0] p_ext;
    logic [SW-1:0] s_ext;
    logic [SW-1:0] end_ext;

    always_comb begin
        p_ext     = {1'b0, pos};
        s_ext     = {1'b0, size};
        end_ext   = p_ext + SW'(len);
        at_end    = p_ext >= s_ext;
        last_byte = (p_ext + SW'(1)) == s_ext;
        len_bad   = (len == 8'd0) || (end_ext > s_ext);
    end
endmodule

// File: rtl/rlw_field_decode.sv
`timescale 1ns/1ps
module rlw_field_decode
    import rlw_pkg::*;
#(
    parameter int PORT_LEN = 8
) (
    input  logic [7:0]       len_byte,
    input  logic [7:0]       flags_byte,
    input  logic             link_bit,
    input  logic             dual_bit,
    input  logic [IDX_W-1:0] partner,
    output walk_rec_t        rec,
    output logic             wants_body,
    output logic             bad_port_len
);
    always_comb begin
        rec          = '0;
        rec.is_port  = flags_byte[TYPE_BIT];
        rec.index    = flags_byte[IDX_W-1:0];
        rec.disabled = flags_byte[TYPE_BIT] & flags_byte[DIS_BIT];
        wants_body   = flags_byte[TYPE_BIT] & ~flags_byte[DIS_BIT];
        bad_port_len = wants_body && (len_byte != 8'(PORT_LEN));

        if (wants_body) begin
            rec.link      = link_bit;
            rec.has_dual  = dual_bit;
            rec.dual_port = dual_bit ? partner : '0;
        end

        if (!flags_byte[TYPE_BIT]) begin
            unique case (flags_byte[IDX_W-1:0])
                6'd1:    rec.tag = TAG_VENDOR;
                6'd2:    rec.tag = TAG_DEVICE;
                default: rec.tag = TAG_NONE;
            endcase
            if (rec.tag != TAG_NONE && len_byte >= 8'd2)
                rec.payload_len = len_byte - 8'd2;
        end
    end
endmodule

// File: rtl/rom_list_walker.sv
`timescale 1ns/1ps
module rom_list_walker
    import rlw_pkg::*;
#(
    parameter int AW        = 16,
    parameter int HDR_BYTES = 22,
    parameter int PORT_LEN  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] total_size,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          rec_valid,
    input  logic          rec_ready,
    output logic          rec_is_port,
    output logic [5:0]    rec_index,
    output logic          rec_disabled,
    output logic          rec_link,
    output logic          rec_has_dual,
    output logic [5:0]    rec_dual_port,
    output logic [1:0]    rec_str_tag,
    output logic [7:0]    rec_payload_len,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [1:0]    err_kind
);
    localparam logic [AW-1:0] START_POS = AW'(HDR_BYTES);

    walk_state_e      state_q, state_d;
    walk_err_e        err_q;
    logic [AW-1:0]    pos_q;
    logic [7:0]       len_q;
    logic [7:0]       flags_q;
    logic             link_q;
    logic             dual_q;
    logic [IDX_W-1:0] partner_q;

    logic       at_end, last_byte, len_bad;
    logic       wants_body, bad_port_len;
    logic [7:0] flags_in;
    logic [7:0] len_in;
    walk_rec_t  rec;

    // The byte being fetched this cycle feeds the checks directly.
    assign len_in   = (state_q == ST_LEN)   ? mem_rdata : len_q;
    assign flags_in = (state_q == ST_FLAGS) ? mem_rdata : flags_q;

    rlw_bounds #(.AW(AW)) u_bounds (
        .pos       (pos_q),
        .size      (total_size),
        .len       (len_in),
        .at_end    (at_end),
        .last_byte (last_byte),
        .len_bad   (len_bad)
    );

    rlw_field_decode #(.PORT_LEN(PORT_LEN)) u_decode (
        .len_byte     (len_q),
        .flags_byte   (flags_in),
        .link_bit     (link_q),
        .dual_bit     (dual_q),
        .partner      (partner_q),
        .rec          (rec),
        .wants_body   (wants_body),
        .bad_port_len (bad_port_len)
    );

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: if (start) state_d = ST_WALK;
            ST_WALK: begin
                if (at_end)         state_d = ST_DONE;
                else if (last_byte) state_d = ST_FAIL;
                else                state_d = ST_LEN;
            end
            ST_LEN:   state_d = len_bad ? ST_FAIL : ST_FLAGS;
            ST_FLAGS: begin
                if (!wants_body)      state_d = ST_EMIT;
                else if (bad_port_len) state_d = ST_FAIL;
                else                  state_d = ST_BODY2;
            end
            ST_BODY2: state_d = ST_BODY3;
            ST_BODY3: state_d = ST_EMIT;
            ST_EMIT:  if (rec_ready) state_d = ST_WALK;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk position, captured bytes and error cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q     <= START_POS;
            len_q     <= '0;
            flags_q   <= '0;
            link_q    <= 1'b0;
            dual_q    <= 1'b0;
            partner_q <= '0;
            err_q     <= ERR_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (start) begin
                        pos_q <= START_POS;
                        err_q <= ERR_NONE;
                    end
                end
                ST_WALK: begin
                    if (!at_end && last_byte) err_q <= ERR_OVERRUN;
                end
                ST_LEN: begin
                    len_q     <= mem_rdata;
                    link_q    <= 1'b0;
                    dual_q    <= 1'b0;
                    partner_q <= '0;
                    if (len_bad) err_q <= ERR_OVERRUN;
                end
                ST_FLAGS: begin
                    flags_q <= mem_rdata;
                    if (bad_port_len) err_q <= ERR_PORTLEN;
                end
                ST_BODY2: begin
                    link_q <= mem_rdata[LINK_BIT];
                    dual_q <= mem_rdata[DUAL_BIT];
                end
                ST_BODY3: partner_q <= mem_rdata[IDX_W-1:0];
                ST_EMIT: begin
                    if (rec_ready) pos_q <= pos_q + AW'(len_q);
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        mem_rd_en = 1'b0;
        mem_addr  = pos_q;
        unique case (state_q)
            ST_WALK:  mem_rd_en = !at_end && !last_byte;
            ST_LEN: begin
                mem_rd_en = !len_bad;
                mem_addr  = pos_q + AW'(1);
            end
            ST_FLAGS: begin
                mem_rd_en = wants_body && !bad_port_len;
                mem_addr  = pos_q + AW'(2);
            end
            ST_BODY2: begin
                mem_rd_en = 1'b1;
                mem_addr  = pos_q + AW'(3);
            end
            default: ;
        endcase

        rec_valid       = (state_q == ST_EMIT);
        busy            = !(state_q inside {ST_IDLE, ST_DONE, ST_FAIL});
        done            = (state_q == ST_DONE);
        error           = (state_q == ST_FAIL);
        err_kind        = err_q;
        rec_is_port     = rec.is_port;
        rec_index       = rec.index;
        rec_disabled    = rec.disabled;
        rec_link        = rec.link;
        rec_has_dual    = rec.has_dual;
        rec_dual_port   = rec.dual_port;
        rec_str_tag     = rec.tag;
        rec_payload_len = rec.payload_len;
    end
endmodule

// File: rtl/rom_list_walker_chk.sv
`timescale 1ns/1ps
module rom_list_walker_chk #(
    parameter int AW        = 16,
    parameter int HDR_BYTES = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] total_size,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_addr,
    input logic          rec_valid,
    input logic          rec_ready,
    input logic          rec_is_port,
    input logic [5:0]    rec_index,
    input logic          rec_disabled,
    input logic          rec_link,
    input logic          rec_has_dual,
    input logic [5:0]    rec_dual_port,
    input logic [1:0]    rec_str_tag,
    input logic [7:0]    rec_payload_len,
    input logic          done,
    input logic          error,
    input logic [1:0]    err_kind
);
    logic [25:0] rec_bits;
    assign rec_bits = {rec_is_port, rec_index, rec_disabled, rec_link, rec_has_dual,
                       rec_dual_port, rec_str_tag, rec_payload_len};

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_bits));

    a_r11_addr_low: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> mem_addr >= AW'(HDR_BYTES));

    a_r11_addr_high: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> mem_addr < total_size);

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    a_r12_err_code: assert property (@(posedge clk) disable iff (!rst_n)
        error == (err_kind != 2'd0));

    a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    a_r12_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error && !start |=> error);

    a_r7_disabled_body: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_disabled |-> rec_is_port && !rec_link && !rec_has_dual && rec_dual_port == 6'd0);

    a_r8_tag_generic: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_str_tag != 2'd0 |-> !rec_is_port && rec_str_tag == rec_index[1:0]);
endmodule

bind rom_list_walker rom_list_walker_chk #(.AW(AW), .HDR_BYTES(HDR_BYTES)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .total_size      (total_size),
    .mem_rd_en       (mem_rd_en),
    .mem_addr        (mem_addr),
    .rec_valid       (rec_valid),
    .rec_ready       (rec_ready),
    .rec_is_port     (rec_is_port),
    .rec_index       (rec_index),
    .rec_disabled    (rec_disabled),
    .rec_link        (rec_link),
    .rec_has_dual    (rec_has_dual),
    .rec_dual_port   (rec_dual_port),
    .rec_str_tag     (rec_str_tag),
    .rec_payload_len (rec_payload_len),
    .done            (done),
    .error           (error),
    .err_kind        (err_kind)
);

// File: tb/rom_list_walker_bench.sv
`timescale 1ns/1ps
module rom_list_walker_bench;
    localparam int AW = 16;
    localparam int HS = 22;

    logic          clk = 1'b0;
    logic          rst_n, start, rec_ready;
    logic [AW-1:0] total_size;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic          rec_valid, rec_is_port, rec_disabled, rec_link, rec_has_dual;
    logic [5:0]    rec_index, rec_dual_port;
    logic [1:0]    rec_str_tag, err_kind;
    logic [7:0]    rec_payload_len;
    logic          busy, done, error;

    always #2 clk = ~clk;

    rom_list_walker #(.AW(AW)) u_rom_list_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .total_size(total_size),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_is_port(rec_is_port),
        .rec_index(rec_index), .rec_disabled(rec_disabled), .rec_link(rec_link),
        .rec_has_dual(rec_has_dual), .rec_dual_port(rec_dual_port),
        .rec_str_tag(rec_str_tag), .rec_payload_len(rec_payload_len),
        .busy(busy), .done(done), .error(error), .err_kind(err_kind)
    );

    logic [7:0] img [256];
    always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= img[mem_addr[7:0]];

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    int          exp_n, exp_status, got_n, wpos;
    logic [25:0] exp_rec [32];
    logic [25:0] got_rec [32];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, expv);
        end
    endtask

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 256; i++) img[i] = v;
    endtask

    task automatic add_ent(input int len, input logic [7:0] f, input logic [7:0] b2, input logic [7:0] b3);
        img[wpos] = 8'(len); img[wpos+1] = f; img[wpos+2] = b2; img[wpos+3] = b3;
        wpos += len;
    endtask

    // Reference walk computed from the requirements.
    task automatic model(input int size);
        int pos, len, plen;
        logic [7:0] f, b2, b3;
        logic port, dis, link, hd;
        logic [5:0] dp;
        logic [1:0] tag;
        exp_n = 0; exp_status = 0; pos = HS;
        while (pos < size) begin
            len = int'(img[pos]);
            if (pos + 1 == size || len == 0 || pos + len > size) begin exp_status = 1; break; end
            f = img[pos+1]; port = f[7]; dis = f[7] & f[6];
            if (port && !dis && len != 8) begin exp_status = 2; break; end
            link = 0; hd = 0; dp = 0; tag = 0; plen = 0;
            if (port && !dis) begin
                b2 = img[pos+2]; b3 = img[pos+3];
                link = b2[4]; hd = b2[7]; dp = hd ? b3[5:0] : 6'd0;
            end
            if (!port && f[5:0] == 6'd1) tag = 2'd1;
            if (!port && f[5:0] == 6'd2) tag = 2'd2;
            if (tag != 0 && len >= 2) plen = len - 2;
            exp_rec[exp_n] = {port, f[5:0], dis, link, hd, dp, tag, 8'(plen)};
            exp_n++;
            pos += len;
        end
    endtask

    function automatic string rec_req(input logic [25:0] r);
        if (r[25] && r[18]) return "R7";
        if (r[25])          return "R6";
        if (r[9:8] != 0)    return "R8";
        return "R3";
    endfunction

    task automatic run_walk(input int size, input int mode, input string name);
        int cyc;
        logic pv, pr;
        logic [25:0] pp, cur;
        bit addr_ok;
        model(size);
        @(negedge clk);
        total_size = AW'(size); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_n = 0; cyc = 0; pv = 0; pr = 0; pp = '0; addr_ok = 1;
        forever begin
            case (mode)
                0: rec_ready = 1'b1;
                1: rec_ready = (cyc % 3) != 0;
                default: rec_ready = (cyc % 5) == 4;
            endcase
            if (done || error) break;
            cur = {rec_is_port, rec_index, rec_disabled, rec_link, rec_has_dual,
                   rec_dual_port, rec_str_tag, rec_payload_len};
            if (pv && !pr)
                check(rec_valid && cur == pp, "R10", {name, " hold"}, 32'(cur), 32'(pp));
            if (rec_valid && rec_ready && got_n < 32) begin got_rec[got_n] = cur; got_n++; end
            if (mem_rd_en && (int'(mem_addr) < HS || int'(mem_addr) >= size)) addr_ok = 0;
            pv = rec_valid; pr = rec_ready; pp = cur;
            cyc++;
            if (cyc > 3000) begin
                check(0, "R2", {name, " walk timeout"}, 32'(cyc), 0);
                break;
            end
            @(negedge clk);
        end
        check(addr_ok, "R11", {name, " read window"}, 32'(addr_ok), 1);
        case (exp_status)
            1: check(error && !done && err_kind == 2'd1, "R4", {name, " status"},
                     {29'd0, done, err_kind}, 32'h1);
            2: check(error && !done && err_kind == 2'd2, "R5", {name, " status"},
                     {29'd0, done, err_kind}, 32'h2);
            default: check(done && !error && err_kind == 2'd0, "R2", {name, " status"},
                     {29'd0, done, err_kind}, 32'h4);
        endcase
        check(got_n == exp_n, "R9", {name, " record count"}, 32'(got_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++)
            check(got_rec[i] == exp_rec[i], rec_req(exp_rec[i]), {name, " record"},
                  32'(got_rec[i]), 32'(exp_rec[i]));
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int sizes [2];
        logic [7:0] fl [4];
        rst_n = 0; start = 0; rec_ready = 0; total_size = '0;
        fill(8'hEE);
        repeat (3) @(negedge clk);
        check(!rec_valid && !done && !error && !busy && !mem_rd_en, "R1", "reset outputs",
              {27'd0, rec_valid, done, error, busy, mem_rd_en}, 0);
        rst_n = 1;
        @(negedge clk);
        check(!rec_valid && !done && !error && !busy && !mem_rd_en, "R1", "idle after reset",
              {27'd0, rec_valid, done, error, busy, mem_rd_en}, 0);

        // Empty chain, then sticky done.
        run_walk(HS, 0, "empty");
        repeat (5) @(negedge clk);
        check(done && !error, "R12", "done sticky", {30'd0, done, error}, 32'h2);

        // Start on the last byte of the image.
        run_walk(HS + 1, 0, "last byte");
        repeat (4) @(negedge clk);
        check(error && !done && err_kind == 2'd1, "R12", "error sticky",
              {29'd0, done, err_kind}, 32'h1);

        // Every flags byte, single eight-byte record.
        for (int f = 0; f < 256; f++) begin
            fill(8'hEE);
            wpos = HS;
            add_ent(8, 8'(f), 8'(f) ^ 8'h5A, 8'(f * 7));
            run_walk(HS + 8, f % 3, "flags sweep");
        end

        // Length sweep against exact and loose sizes.
        fl[0] = 8'h01; fl[1] = 8'h81; fl[2] = 8'hC3; fl[3] = 8'h02;
        for (int k = 0; k < 4; k++)
            for (int len = 0; len <= 12; len++) begin
                sizes[0] = HS + len; sizes[1] = HS + 8;
                for (int s = 0; s < 2; s++) begin
                    fill(8'hEE);
                    wpos = HS;
                    add_ent(len, fl[k], 8'h90, 8'h2B);
                    run_walk(sizes[s], (len + s) % 3, "length sweep");
                end
            end

        // Clean chain under each ready pattern.
        for (int m = 0; m < 3; m++) begin
            fill(8'h00);
            wpos = HS;
            add_ent(6, 8'h01, 8'h41, 8'h42);
            add_ent(8, 8'h83, 8'h90, 8'h25);
            add_ent(3, 8'hC4, 8'hFF, 8'hFF);
            add_ent(4, 8'h02, 8'h44, 8'h45);
            add_ent(2, 8'h05, 8'h00, 8'h00);
            add_ent(8, 8'h87, 8'h6F, 8'hFF);
            run_walk(wpos, m, "chain");
        end

        // Chain whose final record runs past the image.
        fill(8'h00);
        wpos = HS;
        add_ent(8, 8'h81, 8'h80, 8'h07);
        add_ent(5, 8'h02, 8'h00, 8'h00);
        add_ent(9, 8'h03, 8'h00, 8'h00);
        run_walk(wpos - 1, 1, "chain overrun");

        // Enabled port of wrong length inside a chain.
        fill(8'h00);
        wpos = HS;
        add_ent(4, 8'h01, 8'h00, 8'h00);
        add_ent(7, 8'h82, 8'h90, 8'h11);
        run_walk(wpos + 4, 2, "chain port length");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule